// File: doc/BRIEF.md
# Write-Through Data Cache with Store Queue

This block sits between a processor core's load/store port and a simple memory bus. It holds a 2 KB direct-mapped cache of 32-bit words, indexed and tagged by physical word address, so any word of a 4 GB space can be cached. A load that hits returns its data combinationally in the cycle it is presented. A load that misses fetches one word from memory, hands it to the core and installs it.

Every store is written through to memory. A store that hits also merges its enabled bytes into the cached word. A store that misses leaves the cache untouched. Either way the store is placed in a 4-entry first-in first-out queue that holds the word address, the data and the byte enables. The queue accepts one store per cycle and retires entries to the bus as fast as memory acknowledges them.

When the queue is full a store is held off until an entry leaves. A load miss does not issue its bus read until the queue has drained, so memory always holds every earlier store before it is read.

Top module: `dcwt_cache`

## Requirements
- R1: A load that hits asserts `cpu_ready` in the same cycle as `cpu_req`, with the cached word on `cpu_rdata` and no bus read.
- R2: A load that misses issues one read of its word address on `mr_addr`, returns `mr_data` to the core in the cycle `mr_ack` is seen, and installs the word so that the next load of that address hits.
- R3: The cache is direct-mapped with 512 one-word lines: index is `cpu_addr[8:0]` and tag is `cpu_addr[29:9]`, so two addresses 512 words apart evict each other.
- R4: Every accepted store appears on the write port exactly once, in acceptance order, carrying its word address, data and byte enables; `mw_valid` is high exactly while the queue holds an entry.
- R5: A store that hits replaces only the enabled bytes of the cached word, with `cpu_be[i]` selecting bits `[8i+7:8i]`.
- R6: A store that misses does not allocate a line; a later load of that address misses and reads memory.
- R7: With four stores queued, a further store is not accepted (`cpu_ready` low) until an entry has drained.
- R8: A load miss keeps `mr_valid` low while the store queue is not empty; `mr_valid` and `mw_valid` are never high together.
- R9: On both bus ports a raised request stays high, with address (and for writes data and byte enables) unchanged, until it is acknowledged.
- R10: After reset all lines are invalid, the queue is empty and neither bus request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Core access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | 30 | Physical word address |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` on a load |
| mr_valid | output | 1 | Bus read request |
| mr_addr | output | 30 | Bus read word address |
| mr_ack | input | 1 | Bus read acknowledge, data valid |
| mr_data | input | 32 | Bus read data |
| mw_valid | output | 1 | Bus write request (queue head) |
| mw_addr | output | 30 | Bus write word address |
| mw_data | output | 32 | Bus write data |
| mw_be | output | 4 | Bus write byte enables |
| mw_ack | input | 1 | Bus write acknowledge, head retires |

## Verification
The assertions watch every cycle for the bus handshake rules, for a read never overlapping a pending write, and, through an occupancy count kept from port traffic alone, for the queue never taking a fifth store and for the write request tracking queue occupancy. What data a load returns, whether a line was installed, evicted or left unallocated, how bytes merge and in which order stores reach memory can only be shown by the bench's scenarios, which compare port values against a memory model computed from the requirements.

// File: rtl/dcwt_pkg.sv
package dcwt_pkg;
  localparam int WADDR_W = 30;
  localparam int WORD_W  = 32;
  localparam int BE_W    = WORD_W / 8;

  typedef struct packed {
    logic [WADDR_W-1:0] waddr;
    logic [WORD_W-1:0]  data;
    logic [BE_W-1:0]    be;
  } sq_entry_t;

  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_MISS = 1'b1
  } miss_state_t;
endpackage

// File: rtl/dcwt_line_store.sv
module dcwt_line_store
  import dcwt_pkg::*;
#(
  parameter int LINES = 512
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(LINES)-1:0]   idx,
  input  logic [WADDR_W-$clog2(LINES)-1:0] tag,
  output logic                       hit,
  output logic [WORD_W-1:0]          line_data,
  input  logic                       fill_en,
  input  logic [WORD_W-1:0]          fill_data,
  input  logic                       merge_en,
  input  logic [BE_W-1:0]            merge_be,
  input  logic [WORD_W-1:0]          merge_data
);
  localparam int TAG_W = WADDR_W - $clog2(LINES);

  logic [WORD_W-1:0] data_q [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  valid_q;
  logic [WORD_W-1:0] merged;

  assign line_data = data_q[idx];
  assign hit       = valid_q[idx] && (tag_q[idx] == tag);

  // byte-lane merge of a store into the present word
  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign merged[8*b +: 8] = merge_be[b] ? merge_data[8*b +: 8] : line_data[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (fill_en) begin
      valid_q[idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[idx]  <= tag;
      data_q[idx] <= fill_data;
    end else if (merge_en) begin
      data_q[idx] <= merged;
    end
  end
endmodule

// File: rtl/dcwt_store_queue.sv
module dcwt_store_queue
  import dcwt_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  sq_entry_t push_entry,
  input  logic      pop,
  output sq_entry_t head,
  output logic      full,
  output logic      empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  sq_entry_t        slot_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CNT_FULL);
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slot_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && (wr_ptr_q == PTR_W'(s))) slot_q[s] <= push_entry;
    end
  end
endmodule

// File: rtl/dcwt_miss_ctrl.sv
module dcwt_miss_ctrl
  import dcwt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic queue_empty,
  input  logic rd_ack,
  output logic busy,
  output logic rd_valid,
  output logic done
);
  miss_state_t state_q, state_d;

  assign busy     = (state_q == MS_MISS);
  assign rd_valid = busy && queue_empty;
  assign done     = rd_valid && rd_ack;

  always_comb begin
    state_d = state_q;
    case (state_q)
      MS_IDLE: if (start) state_d = MS_MISS;
      MS_MISS: if (done)  state_d = MS_IDLE;
      default:            state_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/dcwt_cache.sv
module dcwt_cache
  import dcwt_pkg::*;
#(
  parameter int CACHE_BYTES = 2048,
  parameter int WB_DEPTH    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req,
  input  logic               cpu_we,
  input  logic [WADDR_W-1:0] cpu_addr,
  input  logic [BE_W-1:0]    cpu_be,
  input  logic [WORD_W-1:0]  cpu_wdata,
  output logic               cpu_ready,
  output logic [WORD_W-1:0]  cpu_rdata,
  output logic               mr_valid,
  output logic [WADDR_W-1:0] mr_addr,
  input  logic               mr_ack,
  input  logic [WORD_W-1:0]  mr_data,
  output logic               mw_valid,
  output logic [WADDR_W-1:0] mw_addr,
  output logic [WORD_W-1:0]  mw_data,
  output logic [BE_W-1:0]    mw_be,
  input  logic               mw_ack
);
  localparam int LINES = CACHE_BYTES / BE_W;
  localparam int IDX_W = $clog2(LINES);

  logic              hit, miss_busy, fill_done, sq_full, sq_empty;
  logic              in_idle, load_hit, load_miss, store_go;
  logic [WORD_W-1:0] line_data;
  sq_entry_t         new_entry, head_entry;

  assign in_idle   = !miss_busy;
  assign load_hit  = cpu_req && !cpu_we && hit && in_idle;
  assign load_miss = cpu_req && !cpu_we && !hit && in_idle;
  assign store_go  = cpu_req && cpu_we && in_idle && !sq_full;

  assign cpu_ready = load_hit || store_go || fill_done;
  assign cpu_rdata = fill_done ? mr_data : line_data;
  assign mr_addr   = cpu_addr;

  assign new_entry = '{waddr: cpu_addr, data: cpu_wdata, be: cpu_be};
  assign mw_valid  = !sq_empty;
  assign mw_addr   = head_entry.waddr;
  assign mw_data   = head_entry.data;
  assign mw_be     = head_entry.be;

  dcwt_line_store #(.LINES(LINES)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (cpu_addr[IDX_W-1:0]),
    .tag        (cpu_addr[WADDR_W-1:IDX_W]),
    .hit        (hit),
    .line_data  (line_data),
    .fill_en    (fill_done),
    .fill_data  (mr_data),
    .merge_en   (store_go && hit),
    .merge_be   (cpu_be),
    .merge_data (cpu_wdata)
  );

  dcwt_store_queue #(.DEPTH(WB_DEPTH)) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (store_go),
    .push_entry (new_entry),
    .pop        (mw_ack),
    .head       (head_entry),
    .full       (sq_full),
    .empty      (sq_empty)
  );

  dcwt_miss_ctrl u_miss (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (load_miss),
    .queue_empty (sq_empty),
    .rd_ack      (mr_ack),
    .busy        (miss_busy),
    .rd_valid    (mr_valid),
    .done        (fill_done)
  );
endmodule

// File: rtl/dcwt_cache_chk.sv
module dcwt_cache_chk #(
  parameter int WB_DEPTH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_we,
  input logic        cpu_ready,
  input logic        mr_valid,
  input logic        mr_ack,
  input logic [29:0] mr_addr,
  input logic        mw_valid,
  input logic        mw_ack,
  input logic [29:0] mw_addr,
  input logic [31:0] mw_data,
  input logic [3:0]  mw_be
);
  localparam int OCC_W = $clog2(WB_DEPTH + 1) + 1;

  logic [OCC_W-1:0] occ_q;
  logic             st_acc, wr_ret;

  assign st_acc = cpu_req && cpu_we && cpu_ready;
  assign wr_ret = mw_valid && mw_ack;

  // occupancy reconstructed from port traffic only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_q + OCC_W'(st_acc) - OCC_W'(wr_ret);
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(WB_DEPTH));

  assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_q == OCC_W'(WB_DEPTH)) |-> !st_acc);

  assert_write_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mw_valid == (occ_q != '0));

  assert_read_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mr_valid && mw_valid));

  assert_wr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ack) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data) && $stable(mw_be)));

  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_valid && !mr_ack) |=> (mr_valid && $stable(mr_addr)));
endmodule

bind dcwt_cache dcwt_cache_chk #(.WB_DEPTH(WB_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_ready (cpu_ready),
  .mr_valid  (mr_valid),
  .mr_ack    (mr_ack),
  .mr_addr   (mr_addr),
  .mw_valid  (mw_valid),
  .mw_ack    (mw_ack),
  .mw_addr   (mw_addr),
  .mw_data   (mw_data),
  .mw_be     (mw_be)
);

// File: tb/tb_dcwt_cache.sv
`timescale 1ns/1ps
module tb_dcwt_cache;
  logic        clk, rst_n;
  logic        cpu_req, cpu_we;
  logic [29:0] cpu_addr;
  logic [3:0]  cpu_be;
  logic [31:0] cpu_wdata;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mr_valid, mr_ack;
  logic [29:0] mr_addr;
  logic [31:0] mr_data;
  logic        mw_valid, mw_ack;
  logic [29:0] mw_addr;
  logic [31:0] mw_data;
  logic [3:0]  mw_be;

  int n_chk = 0;
  int n_fail = 0;

  // bus model state
  logic        wr_hold = 1'b0;
  int          rd_count = 0;
  logic [29:0] rd_last_addr;
  int          wr_seen_at_read = 0;
  logic [29:0] wlog_addr [64];
  logic [31:0] wlog_data [64];
  logic [3:0]  wlog_be   [64];
  int          wlog_n = 0;

  dcwt_cache dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mr_valid(mr_valid), .mr_addr(mr_addr), .mr_ack(mr_ack), .mr_data(mr_data),
    .mw_valid(mw_valid), .mw_addr(mw_addr), .mw_data(mw_data), .mw_be(mw_be),
    .mw_ack(mw_ack)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] pat(logic [29:0] a);
    return {~a[15:0], a[29:14]} ^ 32'h3C3C_5A5A;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // read responder: two wait cycles, then acknowledge
  initial begin
    int wait_n;
    wait_n = 0;
    mr_ack = 1'b0;
    mr_data = '0;
    forever begin
      @(negedge clk);
      mr_ack = 1'b0;
      if (mr_valid) begin
        if (wait_n == 2) begin
          mr_ack = 1'b1;
          mr_data = pat(mr_addr);
          rd_last_addr = mr_addr;
          wr_seen_at_read = wlog_n;
          rd_count++;
          wait_n = 0;
        end else begin
          wait_n++;
        end
      end
    end
  end

  // write responder: one entry per cycle unless held
  initial begin
    mw_ack = 1'b0;
    forever begin
      @(negedge clk);
      mw_ack = 1'b0;
      if (mw_valid && !wr_hold) begin
        mw_ack = 1'b1;
        if (wlog_n < 64) begin
          wlog_addr[wlog_n] = mw_addr;
          wlog_data[wlog_n] = mw_data;
          wlog_be[wlog_n]   = mw_be;
        end
        wlog_n++;
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  task automatic access(input logic we, input logic [29:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output int waits);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_be = be; cpu_wdata = wd;
    waits = 0;
    #1;
    while (!cpu_ready && waits < 1000) begin
      @(negedge clk);
      #1;
      waits++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic drain();
    wr_hold = 1'b0;
    for (int i = 0; i < 50 && mw_valid; i++) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  logic [29:0] A = 30'h0000400;
  logic [29:0] B = 30'h0000600;   // same index as A (512 words apart)
  logic [29:0] C = 30'h00008D1;

  task automatic t_reset();
    #1;
    check("R10", "mw_valid after reset", 32'(mw_valid), 32'd0);
    check("R10", "mr_valid after reset", 32'(mr_valid), 32'd0);
    check("R10", "cpu_ready idle", 32'(cpu_ready), 32'd0);
  endtask

  task automatic t_miss_then_hit();
    logic [31:0] d; int w; int r0;
    r0 = rd_count;
    access(1'b0, A, 4'h0, '0, d, w);
    check("R2", "miss data", d, pat(A));
    check("R2", "one read", 32'(rd_count - r0), 32'd1);
    check("R2", "read address", 32'(rd_last_addr), 32'(A));
    access(1'b0, A, 4'h0, '0, d, w);
    check("R1", "hit data", d, pat(A));
    check("R1", "hit wait cycles", 32'(w), 32'd0);
    check("R1", "no read on hit", 32'(rd_count - r0), 32'd1);
  endtask

  task automatic t_conflict();
    logic [31:0] d; int w; int r0;
    r0 = rd_count;
    access(1'b0, B, 4'h0, '0, d, w);
    check("R3", "conflict line data", d, pat(B));
    access(1'b0, A, 4'h0, '0, d, w);
    check("R3", "evicted line reread", 32'(rd_count - r0), 32'd2);
    check("R3", "evicted line data", d, pat(A));
  endtask

  task automatic t_partial_store();
    logic [31:0] d; int w; int r0; int l0;
    r0 = rd_count; l0 = wlog_n;
    access(1'b1, A, 4'b0011, 32'h1111_2222, d, w);
    check("R5", "store hit wait", 32'(w), 32'd0);
    access(1'b0, A, 4'h0, '0, d, w);
    check("R5", "merged bytes", d, {pat(A)[31:16], 16'h2222});
    check("R5", "no read after store hit", 32'(rd_count - r0), 32'd0);
    drain();
    check("R4", "one write entry", 32'(wlog_n - l0), 32'd1);
    check("R4", "entry address", 32'(wlog_addr[l0]), 32'(A));
    check("R4", "entry data", wlog_data[l0], 32'h1111_2222);
    check("R4", "entry byte enables", 32'(wlog_be[l0]), 32'h3);
  endtask

  task automatic t_store_miss();
    logic [31:0] d; int w; int r0; int l0;
    l0 = wlog_n;
    access(1'b1, C, 4'hF, 32'hDEAD_BEEF, d, w);
    drain();
    check("R6", "store miss written", 32'(wlog_n - l0), 32'd1);
    r0 = rd_count;
    access(1'b0, C, 4'h0, '0, d, w);
    check("R6", "load after store miss reads", 32'(rd_count - r0), 32'd1);
    check("R6", "load after store miss data", d, pat(C));
  endtask

  task automatic t_full_queue();
    logic [31:0] d; int w; int l0;
    l0 = wlog_n;
    wr_hold = 1'b1;
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 30'h0000C00 + 30'(i), 4'hF, 32'hA000_0000 + 32'(i), d, w);
      check("R7", "store into free slot", 32'(w), 32'd0);
    end
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 30'h0000C04; cpu_be = 4'hF;
    cpu_wdata = 32'hA000_0004;
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R7", "fifth store stalled", 32'(cpu_ready), 32'd0);
      @(negedge clk);
    end
    wr_hold = 1'b0;
    w = 0;
    #1;
    while (!cpu_ready && w < 100) begin
      @(negedge clk); #1; w++;
    end
    check("R7", "fifth store accepted after drain", 32'(cpu_ready), 32'd1);
    @(negedge clk);
    cpu_req = 1'b0;
    drain();
    check("R4", "five writes", 32'(wlog_n - l0), 32'd5);
    for (int i = 0; i < 5; i++) begin
      check("R4", "write order address", 32'(wlog_addr[l0 + i]), 32'(30'h0000C00 + 30'(i)));
      check("R4", "write order data", wlog_data[l0 + i], 32'hA000_0000 + 32'(i));
    end
  endtask

  task automatic t_miss_waits();
    logic [31:0] d; int w; int l0;
    l0 = wlog_n;
    wr_hold = 1'b1;
    access(1'b1, 30'h0001000, 4'hF, 32'h5555_AAAA, d, w);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 30'h0001400;
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R8", "read held while queue busy", 32'(mr_valid), 32'd0);
      check("R8", "load not done", 32'(cpu_ready), 32'd0);
      @(negedge clk);
    end
    wr_hold = 1'b0;
    w = 0;
    #1;
    while (!cpu_ready && w < 100) begin
      @(negedge clk); #1; w++;
    end
    check("R8", "miss data after drain", cpu_rdata, pat(30'h0001400));
    check("R8", "store retired before read", 32'(wr_seen_at_read - l0), 32'd1);
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_be = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_then_hit();
    t_conflict();
    t_partial_store();
    t_store_miss();
    t_full_queue();
    t_miss_waits();
    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule